// File: doc/BRIEF.md
# Accelerator Control and Interrupt Register Block

This block sits between a simple 32-bit register bus and a frame-based processing core. Software uses it to launch a frame, to watch the core's progress through done, idle and ready status, to let the core restart on its own after each frame, and to request a flush that only a reset can undo. On the core side it drives a start level, a continue pulse and a flush request. It samples the core's done, ready, idle and flush-complete signals.

Two interrupt sources are tracked: frame done and ready for the next frame. Each source sets a pending bit on its rising edge. Software clears a pending bit by writing 1 to it. A single interrupt line is raised when the global enable is on and at least one pending source is also enabled.

The bus is a single-cycle strobe interface with byte addresses, of which only the word index is decoded. A read strobe loads `bus_rdata` at the clock edge, so the data is valid in the following cycle and reflects the state before that edge. Reading the control word has a side effect: it acknowledges the done flag.

Top module: `accel_ctrl_regs`

## Requirements
- R1: After reset, `core_start`, `flush_req`, `irq` and `bus_rdata` are 0, and all stored control, enable and pending bits are 0.
- R2: A write to offset 0x00 with bit 0 set raises `core_start` at the next edge. While it is set, an edge with `core_ready` high and the auto-restart bit (bit 7) clear drops it. If a start write falls in the same cycle, the write wins.
- R3: Control bit 1 (done) is set at the edge after `core_done` is high. A read of offset 0x00 clears it. If the read and `core_done` fall in the same cycle, the bit stays set.
- R4: Control bits 2 and 3 return the levels of `core_idle` and `core_ready` present in the cycle of the read strobe. Control bit 4 reads 0.
- R5: Writing control bit 5 as 1 raises `flush_req`. Later writes of 0 do not lower it; only reset does.
- R6: Control bit 6 is set at the edge where `flush_done` is high while the flush request is already set. It then stays set until reset.
- R7: Control bit 7 is read/write. `core_continue` equals `core_done` when bit 7 is set. When bit 7 is clear, it is high in the cycle of a read of offset 0x00 that finds the done bit set.
- R8: Offset 0x04 bit 0 (global enable) and offset 0x08 bits 1:0 (per-source enable: bit 0 frame done, bit 1 ready) are read/write. Their other bits read 0.
- R9: At offset 0x0C, bit 0 is set on a rising edge of `core_done` and bit 1 on a rising edge of `core_ready`, whatever the enables. Writing 1 to a bit clears it. A rising edge in the same cycle as the clear wins.
- R10: `irq` equals the global enable ANDed with the OR, over both sources, of pending AND enable. It follows register state with no extra delay.
- R11: Offsets other than 0x00 to 0x0C read 0, and writes to them change nothing.
- R12: `bus_rdata` is loaded only at an edge with `bus_rd_en` high. It holds its value otherwise, and it shows the register contents from before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after the strobe |
| core_start | output | 1 | Start level to the core |
| core_continue | output | 1 | Permission for the core to proceed past done |
| flush_req | output | 1 | Sticky flush request |
| core_done | input | 1 | Core finished the transaction |
| core_ready | input | 1 | Core has consumed its inputs |
| core_idle | input | 1 | Core has no operation running |
| flush_done | input | 1 | Core reports the flush complete |
| irq | output | 1 | Interrupt line |

## Verification
Two pairs of events collide in this block. The first is a clear of a pending bit landing in the same cycle as a new rising edge of its source. The second is a read of the control word arriving in the same cycle as `core_done`. The bench provokes both on purpose in directed sequences and again at random. Its behavioural model gives priority to the set, so a design that lets the clear or the read acknowledgement win shows up as a miscompare of the readback or of `irq` in the following cycles. A start write that coincides with `core_ready` gets the same treatment for R2.

// File: rtl/accel_ctrl_pkg.sv
package accel_ctrl_pkg;
  localparam int NSRC = 2;

  // word indices of the mapped registers
  localparam int W_CTRL = 0;
  localparam int W_GIE  = 1;
  localparam int W_IER  = 2;
  localparam int W_ISR  = 3;

  // control word bit positions (software depends on these)
  localparam int B_START  = 0;
  localparam int B_DONE   = 1;
  localparam int B_IDLE   = 2;
  localparam int B_READY  = 3;
  localparam int B_FLUSH  = 5;
  localparam int B_FSTAT  = 6;
  localparam int B_AUTO   = 7;

  // interrupt source order
  localparam int S_DONE  = 0;
  localparam int S_READY = 1;

  function automatic logic [NSRC-1:0] w1c_next(input logic [NSRC-1:0] cur,
                                               input logic [NSRC-1:0] set,
                                               input logic [NSRC-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic irq_level(input logic gie,
                                     input logic [NSRC-1:0] pend,
                                     input logic [NSRC-1:0] en);
    return gie & (|(pend & en));
  endfunction
endpackage

// File: rtl/acr_decode.sv
module acr_decode #(
  parameter int ADDR_W = 6,
  parameter int NREG   = 4
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   wr_sel,
  output logic [NREG-1:0]   rd_sel
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  assign word = addr[ADDR_W-1:2];

  for (genvar g = 0; g < NREG; g++) begin : g_sel
    assign wr_sel[g] = wr_en && (word == WORD_W'(g));
    assign rd_sel[g] = rd_en && (word == WORD_W'(g));
  end
endmodule

// File: rtl/acr_handshake.sv
module acr_handshake (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctrl,
  input  logic rd_ctrl,
  input  logic wr_start_bit,
  input  logic wr_flush_bit,
  input  logic wr_auto_bit,
  input  logic core_done,
  input  logic core_ready,
  input  logic flush_done,
  output logic start_q,
  output logic auto_q,
  output logic done_q,
  output logic flush_q,
  output logic fstat_q,
  output logic continue_o
);
  logic wr_start;
  assign wr_start = wr_ctrl & wr_start_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      auto_q  <= 1'b0;
      done_q  <= 1'b0;
      flush_q <= 1'b0;
      fstat_q <= 1'b0;
    end else begin
      if (wr_start)                    start_q <= 1'b1;
      else if (core_ready && !auto_q)  start_q <= 1'b0;

      if (wr_ctrl) auto_q <= wr_auto_bit;

      if (core_done)    done_q <= 1'b1;
      else if (rd_ctrl) done_q <= 1'b0;

      if (wr_ctrl && wr_flush_bit) flush_q <= 1'b1;
      if (flush_q && flush_done)   fstat_q <= 1'b1;
    end
  end

  assign continue_o = auto_q ? core_done : (rd_ctrl & done_q);
endmodule

// File: rtl/acr_irq.sv
module acr_irq
  import accel_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_gie,
  input  logic            wr_ier,
  input  logic            wr_isr,
  input  logic [NSRC-1:0] wdata,
  input  logic [NSRC-1:0] src_level,
  output logic            gie_q,
  output logic [NSRC-1:0] ier_q,
  output logic [NSRC-1:0] isr_q,
  output logic [NSRC-1:0] src_rise,
  output logic            irq_o
);
  logic [NSRC-1:0] prev_q;
  logic [NSRC-1:0] clr;

  assign src_rise = src_level & ~prev_q;
  assign clr      = wr_isr ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      ier_q  <= '0;
      isr_q  <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= src_level;
      isr_q  <= w1c_next(isr_q, src_rise, clr);
      if (wr_gie) gie_q <= wdata[0];
      if (wr_ier) ier_q <= wdata;
    end
  end

  assign irq_o = irq_level(gie_q, isr_q, ier_q);
endmodule

// File: rtl/accel_ctrl_regs.sv
module accel_ctrl_regs
  import accel_ctrl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              core_start,
  output logic              core_continue,
  output logic              flush_req,
  input  logic              core_done,
  input  logic              core_ready,
  input  logic              core_idle,
  input  logic              flush_done,
  output logic              irq
);
  localparam int NREG = 4;

  logic [NREG-1:0] wr_sel, rd_sel;
  logic            start_q, auto_q, done_q, flush_q, fstat_q;
  logic            gie_q;
  logic [NSRC-1:0] ier_q, isr_q, src_rise, src_level;
  logic            wr_start;
  logic [DATA_W-1:0] rd_val;

  acr_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) i_dec (
    .wr_en(bus_wr_en), .rd_en(bus_rd_en), .addr(bus_addr),
    .wr_sel(wr_sel), .rd_sel(rd_sel)
  );

  assign wr_start = wr_sel[W_CTRL] & bus_wdata[B_START];

  acr_handshake i_hs (
    .clk(clk), .rst_n(rst_n),
    .wr_ctrl(wr_sel[W_CTRL]), .rd_ctrl(rd_sel[W_CTRL]),
    .wr_start_bit(bus_wdata[B_START]), .wr_flush_bit(bus_wdata[B_FLUSH]),
    .wr_auto_bit(bus_wdata[B_AUTO]),
    .core_done(core_done), .core_ready(core_ready), .flush_done(flush_done),
    .start_q(start_q), .auto_q(auto_q), .done_q(done_q),
    .flush_q(flush_q), .fstat_q(fstat_q), .continue_o(core_continue)
  );

  assign src_level[S_DONE]  = core_done;
  assign src_level[S_READY] = core_ready;

  acr_irq i_irq (
    .clk(clk), .rst_n(rst_n),
    .wr_gie(wr_sel[W_GIE]), .wr_ier(wr_sel[W_IER]), .wr_isr(wr_sel[W_ISR]),
    .wdata(bus_wdata[NSRC-1:0]), .src_level(src_level),
    .gie_q(gie_q), .ier_q(ier_q), .isr_q(isr_q), .src_rise(src_rise),
    .irq_o(irq)
  );

  always_comb begin
    rd_val = '0;
    if (rd_sel[W_CTRL]) begin
      rd_val[B_START] = start_q;
      rd_val[B_DONE]  = done_q;
      rd_val[B_IDLE]  = core_idle;
      rd_val[B_READY] = core_ready;
      rd_val[B_FLUSH] = flush_q;
      rd_val[B_FSTAT] = fstat_q;
      rd_val[B_AUTO]  = auto_q;
    end else if (rd_sel[W_GIE]) begin
      rd_val[0] = gie_q;
    end else if (rd_sel[W_IER]) begin
      rd_val[NSRC-1:0] = ier_q;
    end else if (rd_sel[W_ISR]) begin
      rd_val[NSRC-1:0] = isr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bus_rdata <= '0;
    else if (bus_rd_en) bus_rdata <= rd_val;
  end

  assign core_start = start_q;
  assign flush_req  = flush_q;
endmodule

// File: rtl/acr_checker.sv
module acr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       core_ready,
  input logic       core_done,
  input logic       wr_start,
  input logic       start_q,
  input logic       auto_q,
  input logic       done_q,
  input logic       flush_q,
  input logic       gie_q,
  input logic       irq,
  input logic [1:0] src_rise,
  input logic [1:0] isr_q
);
  p_start_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && core_ready && !auto_q && !wr_start) |=> !start_q);

  p_start_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> start_q);

  p_done_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |=> done_q);

  p_flush_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |=> flush_q);

  p_done_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    src_rise[0] |=> isr_q[0]);

  p_ready_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    src_rise[1] |=> isr_q[1]);

  p_gie_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q |-> !irq);

  p_no_pend_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_q == 2'b00) |-> !irq);
endmodule

bind accel_ctrl_regs acr_checker i_chk (
  .clk(clk), .rst_n(rst_n), .core_ready(core_ready), .core_done(core_done),
  .wr_start(wr_start), .start_q(start_q), .auto_q(auto_q), .done_q(done_q),
  .flush_q(flush_q), .gie_q(gie_q), .irq(irq), .src_rise(src_rise),
  .isr_q(isr_q)
);

// File: tb/test_accel_ctrl_regs.sv
module test_accel_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        c_start, c_cont, f_req, irq;
  logic        c_done = 1'b0, c_ready = 1'b0, c_idle = 1'b1, f_done = 1'b0;

  int vectors = 0;
  int fails = 0;

  always #2 clk = ~clk;

  accel_ctrl_regs i_accel_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(wr), .bus_rd_en(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .core_start(c_start),
    .core_continue(c_cont), .flush_req(f_req), .core_done(c_done),
    .core_ready(c_ready), .core_idle(c_idle), .flush_done(f_done), .irq(irq)
  );

  // behavioural reference model
  bit m_start, m_auto, m_done, m_flush, m_fstat, m_gie;
  bit [1:0] m_ier, m_isr, m_prev;
  bit [31:0] m_rdata;
  int last_rd_word = 0;

  function automatic bit [31:0] model_read(int w);
    bit [31:0] v = 0;
    case (w)
      0: v = {24'd0, m_auto, m_fstat, m_flush, 1'b0, c_ready, c_idle, m_done, m_start};
      1: v = {31'd0, m_gie};
      2: v = {30'd0, m_ier};
      3: v = {30'd0, m_isr};
      default: v = 0;
    endcase
    return v;
  endfunction

  always @(posedge clk) begin
    int w;
    bit [1:0] rise, clr;
    bit fl_old;
    w = int'(addr >> 2);
    if (!rst_n) begin
      m_start = 0; m_auto = 0; m_done = 0; m_flush = 0; m_fstat = 0;
      m_gie = 0; m_ier = 0; m_isr = 0; m_prev = 0; m_rdata = 0;
    end else begin
      if (rd) begin m_rdata = model_read(w); last_rd_word = w; end
      rise = {c_ready, c_done} & ~m_prev;
      clr  = (wr && w == 3) ? wdata[1:0] : 2'b00;
      m_prev = {c_ready, c_done};
      m_isr = (m_isr & ~clr) | rise;
      if (wr && w == 0 && wdata[0]) m_start = 1;
      else if (c_ready && !m_auto)  m_start = 0;
      if (c_done) m_done = 1;
      else if (rd && w == 0) m_done = 0;
      fl_old = m_flush;
      if (wr && w == 0 && wdata[5]) m_flush = 1;
      if (fl_old && f_done) m_fstat = 1;
      if (wr && w == 0) m_auto = wdata[7];
      if (wr && w == 1) m_gie = wdata[0];
      if (wr && w == 2) m_ier = wdata[1:0];
    end
  end

  task automatic fail(string tag, logic [31:0] act, logic [31:0] exp);
    fails++;
    $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
  endtask

  function automatic string rd_tag(int w);
    case (w)
      0: return "R2 R3 R4 R5 R6 R7 R12";
      1, 2: return "R8 R12";
      3: return "R9 R12";
      default: return "R11 R12";
    endcase
  endfunction

  task automatic compare();
    bit e_cont, e_irq;
    int w = int'(addr >> 2);
    e_cont = m_auto ? c_done : (rd && rst_n && w == 0 && m_done);
    e_irq  = m_gie & (|(m_isr & m_ier));
    vectors++;
    if (c_start !== m_start) fail("R2", 32'(c_start), 32'(m_start));
    if (c_cont !== e_cont)   fail("R7", 32'(c_cont), 32'(e_cont));
    if (f_req !== m_flush)   fail("R5", 32'(f_req), 32'(m_flush));
    if (irq !== e_irq)       fail("R10", 32'(irq), 32'(e_irq));
    if (rdata !== m_rdata)   fail(rd_tag(last_rd_word), rdata, m_rdata);
  endtask

  // one cycle: check current outputs, then drive the next input set
  task automatic cyc(bit r, bit w, bit [5:0] a, bit [31:0] d,
                     bit dn, bit rdy, bit idl, bit fd);
    @(negedge clk);
    compare();
    rd = r; wr = w; addr = a; wdata = d;
    c_done = dn; c_ready = rdy; c_idle = idl; f_done = fd;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    rd = 0; wr = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    vectors++;  // R1: reset state at the ports
    if ({c_start, f_req, irq} !== 3'b000 || rdata !== 32'd0)
      fail("R1", {c_start, f_req, irq, rdata[28:0]}, 32'd0);
    cyc(1, 0, 6'h00, 0, 0, 0, 1, 0);   // R1 R4: idle reads back as bit 2
    cyc(1, 0, 6'h0C, 0, 0, 0, 1, 0);
    cyc(0, 1, 6'h04, 32'hFFFF_FFFF, 0, 0, 1, 0); // R8
    cyc(0, 1, 6'h08, 32'hFFFF_FFFF, 0, 0, 1, 0);
    cyc(1, 0, 6'h08, 0, 0, 0, 1, 0);
    // R2: start, core busy, ready drops start
    cyc(0, 1, 6'h00, 32'h1, 0, 0, 1, 0);
    cyc(1, 0, 6'h00, 0, 0, 0, 0, 0);
    cyc(0, 0, 6'h00, 0, 0, 1, 0, 0);
    cyc(0, 0, 6'h00, 0, 0, 0, 0, 0);
    // R2: start write coincident with ready keeps start
    cyc(0, 1, 6'h00, 32'h1, 0, 1, 0, 0);
    cyc(0, 0, 6'h00, 0, 0, 0, 0, 0);
    // R3 R7: done together with control read, set wins
    cyc(1, 0, 6'h00, 0, 1, 0, 0, 0);
    cyc(1, 0, 6'h00, 0, 0, 0, 1, 0);
    cyc(1, 0, 6'h00, 0, 0, 0, 1, 0);
    // R9: clear pending done in same cycle as new rising edge
    cyc(0, 0, 6'h0C, 0, 0, 0, 1, 0);
    cyc(0, 1, 6'h0C, 32'h3, 1, 0, 1, 0);
    cyc(1, 0, 6'h0C, 0, 0, 0, 1, 0);
    cyc(0, 1, 6'h0C, 32'h3, 0, 0, 1, 0);   // R10: irq falls
    cyc(1, 0, 6'h0C, 0, 0, 0, 1, 0);
    // R7 R2: auto restart keeps start and forwards done
    cyc(0, 1, 6'h00, 32'h81, 0, 0, 0, 0);
    cyc(0, 0, 6'h00, 0, 0, 1, 0, 0);
    cyc(0, 0, 6'h00, 0, 1, 0, 0, 0);
    cyc(1, 0, 6'h00, 0, 0, 1, 0, 0);
    cyc(0, 1, 6'h00, 32'h0, 0, 1, 0, 0);
    cyc(0, 0, 6'h00, 0, 0, 1, 1, 0);
    // R11: unmapped offsets
    cyc(0, 1, 6'h10, 32'hFFFF_FFFF, 0, 0, 1, 0);
    cyc(0, 1, 6'h3C, 32'hFFFF_FFFF, 0, 0, 1, 0);
    cyc(1, 0, 6'h10, 0, 0, 0, 1, 0);
    cyc(1, 0, 6'h00, 0, 0, 0, 1, 0);
    // R5 R6: sticky flush and its status
    cyc(0, 0, 6'h00, 0, 0, 0, 1, 1);    // flush_done before request: ignored
    cyc(1, 0, 6'h00, 0, 0, 0, 1, 0);
    cyc(0, 1, 6'h00, 32'h20, 0, 0, 1, 0);
    cyc(0, 1, 6'h00, 32'h00, 0, 0, 1, 0);
    cyc(0, 0, 6'h00, 0, 0, 0, 1, 1);
    cyc(1, 0, 6'h00, 0, 0, 0, 1, 0);
    cyc(0, 0, 6'h00, 0, 0, 0, 1, 0);
    do_reset();
    // random mix with periodic resets
    for (int i = 0; i < 4000; i++) begin
      bit [5:0] a;
      a = {$urandom_range(0, 5) == 5 ? 4'($urandom_range(4, 15)) : 4'($urandom_range(0, 3)), 2'b00};
      if (i % 700 == 699) do_reset();
      cyc($urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0, a, $urandom(),
          $urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0,
          $urandom_range(0, 1) == 0, $urandom_range(0, 5) == 0);
    end
    cyc(0, 0, 6'h00, 0, 0, 0, 1, 0);
    cyc(0, 0, 6'h00, 0, 0, 0, 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule